// File: doc/BRIEF.md
# Cartridge ROM transfer controller

This block runs one command-and-read transaction against a cartridge ROM at a time. A host loads an eight-byte command into two command words, arms the interface through an auxiliary control register, and then writes a control word with the start bit set. The block decodes a block length from a three-bit field and delivers the block as 32-bit words through a data port. A pacing counter spaces the words apart. Each new word raises a ready flag and sends a one-cycle DMA request. When the last word has been read, busy clears, and a completion interrupt pulse is issued if it is enabled.

The data source depends on the command opcode. It can be an all-ones fill, a repeated chip identifier, or the ROM header read through a plain word-addressed memory port, which wraps at the header size. Other opcodes return zero words. Only one of two CPUs may use the block at a time. An external owner-select bit names that CPU, and accesses from the other one are ignored.

The controller is a three-state machine with these states:

- ST_IDLE: no transfer is in progress.
- ST_PACE: the block waits out the per-word delay. On entry it has already put the header word index of the next word on the memory port.
- ST_READY: one word is held for the host.

It has these transitions:

- launch: ST_IDLE to ST_PACE, on a start with a non-zero length.
- empty_end: ST_IDLE back to ST_IDLE, on a start with zero length.
- paced: ST_PACE to ST_READY, when the delay has elapsed.
- next_word: ST_READY to ST_PACE, on an owner read with words still to come.
- last_word: ST_READY to ST_IDLE, on the owner read of the final word.

Top module: `cart_xfer_ctrl`

## Requirements
- R1: After reset, every register reads 0, and busy, data_ready, dma_req and irq are low. The register indices are: 0 auxiliary, 1 control, 2 command low (byte 0, the opcode, in bits 7:0), 3 command high, 4 data.
- R2: Writes to the control register are stored through the mask 0xFF7F7FFF, so bits 23 and 15 always read 0. Control bit 31 reads back as busy and bit 23 reads back as data_ready. For example, with the interface disarmed, writing 0xFFFFFFFF reads back 0x7F7F7FFF.
- R3: A transfer starts only if the control write has bit 31 set and auxiliary bit 15 (enable) is already set. Otherwise busy stays low.
- R4: Control bits 26:24 give the length in bytes. Code 0 gives 0 bytes, code 7 gives 4 bytes, and codes 1 to 6 give 0x100 shifted left by the code.
- R5: A start with code 0 never raises busy. It gives a one-cycle irq in the cycle after the start if auxiliary bit 14 is set.
- R6: Each word becomes ready exactly 5 cycles after the launch (or after the previous read), or 8 cycles if control bit 27 was set at the start. data_ready and a one-cycle dma_req rise together.
- R7: An owner read of index 4 while data_ready is high returns the word and advances the position by 4 bytes, and data_ready is low in the following cycle. A data read while not ready returns 0 and has no effect.
- R8: The owner read of the final word clears busy and data_ready. It pulses irq for one cycle exactly when auxiliary bit 14 is set.
- R9: Opcode 0x9F returns 0xFFFFFFFF words.
- R10: Opcodes 0x90 and 0xB8, and every opcode 0x1X, return the CHIP_ID parameter in every word.
- R11: Opcode 0x00 returns the ROM header starting at byte 0. The word at byte position p is read at rom_addr = (p/4) mod 2^ROM_AW, so the data repeats every header length. Every other opcode returns 0 words.
- R12: An access whose host_cpu differs from owner_sel is ignored. Its writes change nothing, and its reads, including data reads, return 0 without advancing the position.
- R13: Control writes are ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| owner_sel | input | 1 | Number of the CPU that owns the interface |
| host_cpu | input | 1 | Number of the CPU making the current access |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 3 | Register index |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid in the cycle of host_rd |
| rom_addr | output | ROM_AW | Header word index |
| rom_rdata | input | 32 | Header word at rom_addr, combinational |
| busy | output | 1 | Transfer in progress |
| data_ready | output | 1 | A word is waiting at the data port |
| dma_req | output | 1 | One-cycle pulse per new word |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The hardest case to reach from the ports is the header wrap for opcode 0x00. It appears only after more than a thousand words, so the stimulus runs the largest size code with that opcode and checks every word against the header pattern. A second case is a foreign-CPU data read landing while a word is held. The bench issues it at a word in the middle of the block and then confirms that the owner still gets that same word. Opcodes, pacing and interrupt enable are drawn with a fixed seed, and every size code is covered.

// File: rtl/cart_xfer_pkg.sv
package cart_xfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PACE  = 2'd1,
        ST_READY = 2'd2
    } xfer_state_t;

    localparam int LEN_W = 15;

    localparam logic [2:0] RA_AUX    = 3'd0;
    localparam logic [2:0] RA_CTRL   = 3'd1;
    localparam logic [2:0] RA_CMD_LO = 3'd2;
    localparam logic [2:0] RA_CMD_HI = 3'd3;
    localparam logic [2:0] RA_DATA   = 3'd4;

    localparam logic [31:0] CTRL_WMASK = 32'hFF7F7FFF;

    localparam int CB_START = 31;
    localparam int CB_SLOW  = 27;
    localparam int CB_READY = 23;
    localparam int AB_ARM   = 15;
    localparam int AB_IRQEN = 14;

    function automatic logic [LEN_W-1:0] block_bytes(input logic [2:0] code);
        logic [15:0] shifted;
        shifted = 16'h0100 << code;
        case (code)
            3'd0:    return '0;
            3'd7:    return LEN_W'(4);
            default: return shifted[LEN_W-1:0];
        endcase
    endfunction

endpackage

// File: rtl/cart_regs.sv
module cart_regs
    import cart_xfer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_ok,
    input  logic        host_wr,
    input  logic [2:0]  host_addr,
    input  logic [31:0] host_wdata,
    input  logic        busy,
    output logic [15:0] aux_q,
    output logic [31:0] ctrl_q,
    output logic [31:0] cmd_lo_q,
    output logic [31:0] cmd_hi_q,
    output logic        launch
);

    logic wr_ok;
    assign wr_ok = acc_ok && host_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux_q    <= '0;
            ctrl_q   <= '0;
            cmd_lo_q <= '0;
            cmd_hi_q <= '0;
        end else if (wr_ok) begin
            case (host_addr)
                RA_AUX:    aux_q    <= host_wdata[15:0];
                RA_CTRL:   if (!busy) ctrl_q <= host_wdata & CTRL_WMASK & ~(32'h1 << CB_START);
                RA_CMD_LO: cmd_lo_q <= host_wdata;
                RA_CMD_HI: cmd_hi_q <= host_wdata;
                default:   ;
            endcase
        end
    end

    assign launch = wr_ok && (host_addr == RA_CTRL) && !busy
                 && host_wdata[CB_START] && aux_q[AB_ARM];

    assert_foreign_wr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !acc_ok) |=> ($stable(aux_q) && $stable(cmd_lo_q) && $stable(ctrl_q)))
        else $error("foreign write changed a register");

    assert_ctrl_frozen_R13: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ctrl_q))
        else $error("control changed while busy");

endmodule

// File: rtl/cart_pacer.sv
module cart_pacer #(
    parameter int FAST_CYC = 5,
    parameter int SLOW_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow,
    output logic done
);

    localparam int MAX_CYC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_cnt;

    assign last_cnt = slow ? CW'(SLOW_CYC - 1) : CW'(FAST_CYC - 1);
    assign done     = run && (cnt_q == last_cnt);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || done) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= last_cnt))
        else $error("pace counter overran");

endmodule

// File: rtl/cart_word_src.sv
module cart_word_src #(
    parameter logic [31:0] CHIP_ID = 32'h00001FC2,
    parameter int          ROM_AW  = 10
) (
    input  logic [7:0]        opcode,
    input  logic [ROM_AW-1:0] word_idx,
    input  logic [31:0]       rom_rdata,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [31:0]       word
);

    assign rom_addr = word_idx;

    always_comb begin
        word = '0;
        if (opcode == 8'h9F)                                       word = '1;
        else if (opcode == 8'h90 || opcode == 8'hB8 || opcode[7:4] == 4'h1) word = CHIP_ID;
        else if (opcode == 8'h00)                                  word = rom_rdata;
    end

endmodule

// File: rtl/cart_xfer_ctrl.sv
module cart_xfer_ctrl
    import cart_xfer_pkg::*;
#(
    parameter logic [31:0] CHIP_ID  = 32'h00001FC2,
    parameter int          FAST_CYC = 5,
    parameter int          SLOW_CYC = 8,
    parameter int          ROM_AW   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              owner_sel,
    input  logic              host_cpu,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [2:0]        host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [31:0]       rom_rdata,
    output logic              busy,
    output logic              data_ready,
    output logic              dma_req,
    output logic              irq
);

    xfer_state_t      state_q, state_d;
    logic [LEN_W-1:0] pos_q, len_q, start_len;
    logic [7:0]       opcode_q;
    logic             slow_q;
    logic [31:0]      data_q, next_word;
    logic [15:0]      aux_q;
    logic [31:0]      ctrl_q, cmd_lo_q, cmd_hi_q;
    logic             launch, acc_ok, take, last, pace_done;

    assign acc_ok    = (host_cpu == owner_sel);
    assign start_len = block_bytes(host_wdata[26:24]);
    assign take      = acc_ok && host_rd && (host_addr == RA_DATA) && (state_q == ST_READY);
    assign last      = ((len_q - pos_q) == LEN_W'(4));

    cart_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_ok     (acc_ok),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .busy       (busy),
        .aux_q      (aux_q),
        .ctrl_q     (ctrl_q),
        .cmd_lo_q   (cmd_lo_q),
        .cmd_hi_q   (cmd_hi_q),
        .launch     (launch)
    );

    cart_pacer #(.FAST_CYC(FAST_CYC), .SLOW_CYC(SLOW_CYC)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_PACE),
        .slow  (slow_q),
        .done  (pace_done)
    );

    cart_word_src #(.CHIP_ID(CHIP_ID), .ROM_AW(ROM_AW)) u_src (
        .opcode    (opcode_q),
        .word_idx  (pos_q[ROM_AW+1:2]),
        .rom_rdata (rom_rdata),
        .rom_addr  (rom_addr),
        .word      (next_word)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: launch, empty_end, paced, next_word, last_word
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch && start_len != '0) state_d = ST_PACE;
            ST_PACE:  if (pace_done)                 state_d = ST_READY;
            ST_READY: if (take)                      state_d = last ? ST_IDLE : ST_PACE;
            default:                                 state_d = ST_IDLE;
        endcase
    end

    // datapath and pulse outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q    <= '0;
            len_q    <= '0;
            opcode_q <= '0;
            slow_q   <= 1'b0;
            data_q   <= '0;
            irq      <= 1'b0;
            dma_req  <= 1'b0;
        end else begin
            irq     <= 1'b0;
            dma_req <= 1'b0;
            if (launch) begin
                pos_q    <= '0;
                len_q    <= start_len;
                opcode_q <= cmd_lo_q[7:0];
                slow_q   <= host_wdata[CB_SLOW];
                if (start_len == '0) irq <= aux_q[AB_IRQEN];
            end
            if (state_q == ST_PACE && pace_done) begin
                data_q  <= next_word;
                dma_req <= 1'b1;
            end
            if (take) begin
                pos_q <= pos_q + LEN_W'(4);
                if (last) irq <= aux_q[AB_IRQEN];
            end
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign data_ready = (state_q == ST_READY);

    always_comb begin
        host_rdata = '0;
        if (acc_ok && host_rd) begin
            case (host_addr)
                RA_AUX:    host_rdata = {16'h0, aux_q};
                RA_CTRL:   host_rdata = {busy, ctrl_q[30:24], data_ready, ctrl_q[22:0]};
                RA_CMD_LO: host_rdata = cmd_lo_q;
                RA_CMD_HI: host_rdata = cmd_hi_q;
                RA_DATA:   host_rdata = data_ready ? data_q : 32'h0;
                default:   host_rdata = '0;
            endcase
        end
    end

    assert_ready_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |-> busy)
        else $error("ready without busy");

    assert_dma_with_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> dma_req)
        else $error("ready rose without dma request");

    assert_dma_needs_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> data_ready)
        else $error("dma request without ready word");

    assert_irq_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy)
        else $error("irq while busy");

    assert_pos_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pos_q < len_q))
        else $error("position beyond block length");

    assert_ready_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !data_ready)
        else $error("ready held after a read");

endmodule

// File: tb/sim_cart_xfer_ctrl.sv
`timescale 1ns/1ps
module sim_cart_xfer_ctrl;

    localparam int          ROM_AW  = 10;
    localparam logic [31:0] CHIP_ID = 32'h00001FC2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        owner_sel = 1'b0;
    logic        host_cpu = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [ROM_AW-1:0] rom_addr;
    logic [31:0] rom_rdata;
    logic        busy, data_ready, dma_req, irq;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    function automatic logic [31:0] rom_fn(input logic [ROM_AW-1:0] a);
        return ({22'h0, a} * 32'h00019E37) ^ 32'h5A5A0000;
    endfunction

    assign rom_rdata = rom_fn(rom_addr);

    cart_xfer_ctrl #(.CHIP_ID(CHIP_ID), .ROM_AW(ROM_AW)) u0 (
        .clk(clk), .rst_n(rst_n), .owner_sel(owner_sel), .host_cpu(host_cpu),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .rom_addr(rom_addr),
        .rom_rdata(rom_rdata), .busy(busy), .data_ready(data_ready),
        .dma_req(dma_req), .irq(irq)
    );

    function automatic int exp_len(input int code);
        if (code == 0) return 0;
        if (code == 7) return 4;
        return 256 << code;
    endfunction

    function automatic logic [31:0] exp_word(input logic [7:0] op, input int pos);
        if (op == 8'h9F) return 32'hFFFFFFFF;
        if (op == 8'h90 || op == 8'hB8 || op[7:4] == 4'h1) return CHIP_ID;
        if (op == 8'h00) return rom_fn(ROM_AW'(pos / 4));
        return 32'h0;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the write edge
    task automatic bus_wr(input logic cpu, input logic [2:0] a, input logic [31:0] d);
        host_cpu = cpu; host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic cpu, input logic [2:0] a, output logic [31:0] d);
        host_cpu = cpu; host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wait_ready();
        for (int k = 0; k < 20 && !data_ready; k++) @(negedge clk);
    endtask

    // variant: 0 plain, 1 foreign data read mid-block, 2 control write while busy
    task automatic run_xfer(input logic cpu, input int code, input logic [7:0] op,
                            input bit slow, input bit irqen, input int variant);
        logic [31:0] rd;
        int len, n;
        len = exp_len(code);
        bus_wr(cpu, 3'd2, {24'hC0FFEE, op});
        bus_wr(cpu, 3'd3, $urandom);
        bus_wr(cpu, 3'd0, 32'h8000 | (32'(irqen) << 14));
        bus_wr(cpu, 3'd1, 32'h80000000 | (32'(slow) << 27) | (32'(code) << 24));
        if (len == 0) begin
            check(busy == 1'b0, "R5 empty block busy", 32'(busy), 0);
            check(irq == irqen, "R5 empty block irq", 32'(irq), 32'(irqen));
            return;
        end
        check(busy == 1'b1, "R3 launch busy", 32'(busy), 1);
        n = 0;
        while (!data_ready && n < 20) begin @(negedge clk); n++; end
        check(n == (slow ? 8 : 5), "R6 first word latency", 32'(n), slow ? 8 : 5);
        check(dma_req == 1'b1, "R6 dma pulse", 32'(dma_req), 1);
        for (int pos = 0; pos < len; pos += 4) begin
            wait_ready();
            if (pos == 4 && variant == 1) begin
                bus_rd(!cpu, 3'd4, rd);
                check(rd == 0, "R12 foreign data read", rd, 0);
            end
            if (pos == 4 && variant == 2) begin
                bus_wr(cpu, 3'd1, 32'h0);
                bus_rd(cpu, 3'd1, rd);
                check(rd == (32'h80800000 | (32'(slow) << 27) | (32'(code) << 24)),
                      "R13 control frozen", rd, 32'h80800000 | (32'(slow) << 27) | (32'(code) << 24));
            end
            bus_rd(cpu, 3'd4, rd);
            check(rd == exp_word(op, pos), "R9 R10 R11 data word", rd, exp_word(op, pos));
            if (pos + 4 < len) begin
                check(data_ready == 1'b0 && busy == 1'b1, "R7 ready drops after read",
                      {30'h0, busy, data_ready}, 32'h2);
            end else begin
                check(busy == 1'b0 && data_ready == 1'b0, "R8 end clears busy",
                      {30'h0, busy, data_ready}, 0);
                check(irq == irqen, "R8 end irq", 32'(irq), 32'(irqen));
            end
        end
        bus_rd(cpu, 3'd4, rd);
        check(rd == 0, "R7 read past end", rd, 0);
    endtask

    initial begin
        logic [31:0] rd;
        logic [7:0] ops [8];
        int seed_sink;
        seed_sink = $urandom(32'd4242);
        ops = '{8'h9F, 8'h90, 8'hB8, 8'h1C, 8'h00, 8'h55, 8'h17, 8'h3A};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check({busy, data_ready, dma_req, irq} == 0, "R1 reset flags", {28'h0, busy, data_ready, dma_req, irq}, 0);
        for (int a = 0; a < 5; a++) begin
            bus_rd(1'b0, 3'(a), rd);
            check(rd == 0, "R1 reset register", rd, 0);
        end

        // R2 / R3: disarmed start, mask readback
        bus_wr(1'b0, 3'd1, 32'hFFFFFFFF);
        check(busy == 1'b0, "R3 no start when disarmed", 32'(busy), 0);
        bus_rd(1'b0, 3'd1, rd);
        check(rd == 32'h7F7F7FFF, "R2 control mask", rd, 32'h7F7F7FFF);

        // R12: foreign accesses
        bus_wr(1'b1, 3'd0, 32'hFFFF);
        bus_rd(1'b0, 3'd0, rd);
        check(rd == 0, "R12 foreign write ignored", rd, 0);
        bus_rd(1'b1, 3'd1, rd);
        check(rd == 0, "R12 foreign read zero", rd, 0);
        bus_wr(1'b1, 3'd1, 32'h87000000);
        check(busy == 1'b0, "R12 foreign start ignored", 32'(busy), 0);

        // R4 every size code, directed opcodes
        run_xfer(1'b0, 0, 8'h9F, 1'b0, 1'b1, 0);
        run_xfer(1'b0, 0, 8'h9F, 1'b0, 1'b0, 0);
        run_xfer(1'b0, 7, 8'h90, 1'b1, 1'b1, 0);
        run_xfer(1'b0, 1, 8'hB8, 1'b0, 1'b1, 1);
        run_xfer(1'b0, 2, 8'h1C, 1'b1, 1'b0, 2);
        run_xfer(1'b0, 3, 8'h9F, 1'b0, 1'b0, 0);
        run_xfer(1'b0, 4, 8'h00, 1'b0, 1'b1, 0);
        run_xfer(1'b0, 5, 8'h55, 1'b0, 1'b1, 0);
        run_xfer(1'b0, 6, 8'h00, $urandom_range(0, 1) == 1, 1'b1, 1); // R11 header wrap

        // owner switch
        owner_sel = 1'b1;
        @(negedge clk);
        run_xfer(1'b1, 7, 8'h1F, 1'b0, 1'b1, 0);
        run_xfer(1'b1, 1, 8'h00, 1'b1, 1'b0, 1);

        // constrained random short blocks
        for (int t = 0; t < 12; t++) begin
            int code;
            logic [7:0] op;
            code = ($urandom_range(0, 3) == 0) ? 7 : int'($urandom_range(0, 2));
            op = ($urandom_range(0, 1) == 1) ? ops[$urandom_range(0, 7)] : 8'($urandom);
            run_xfer(owner_sel, code, op, $urandom_range(0, 1) == 1,
                     $urandom_range(0, 1) == 1, int'($urandom_range(0, 2)));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=%h exp=%h", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule